// File: doc/BRIEF.md
# Reset and Interval Measurement Scheduler

This block sequences the digital side of an eight-input capacitive sensing front end. On power-up (the asynchronous system reset) and after an accepted external active-low reset it keeps the front end in reset. During that time the interrupt line is high and the sensor-side pins are released to high impedance. The reset is released after a fixed number of timebase ticks. At that moment the interrupt line falls, which tells the host that the block has left reset.

Once out of reset, the block runs measurement cycles. Each cycle visits every input once in ascending order. For each input it raises a conversion request, and it moves to the next input only after the converter returns a one-clock done strobe. After the last input it raises the interrupt for one tick and then sleeps. A new cycle begins a programmable number of ticks after the start of the previous one, using either a long or a short interval. The choice between them is captured as the block enters sleep. If a cycle runs past the chosen interval, the next cycle begins straight after the interrupt tick.

States: `ST_HOLD` (external reset held and accepted), `ST_REL_WAIT` (release delay count), `ST_MEASURE` (one input converting), `ST_CYCLE_IRQ` (end-of-cycle interrupt), `ST_SLEEP` (waiting for the interval). Transitions:
- hold→rel_wait when the pin returns high.
- rel_wait→measure when the delay count is reached.
- measure→measure on a done strobe for a non-last input.
- measure→cycle_irq on the done strobe for the last input.
- cycle_irq→sleep on a tick.
- sleep→measure when the interval has expired.
- any→hold on an accepted external reset.

Top module: `sense_sched`

## Requirements
- R1: While the system reset is low, and for exactly REL_TICKS ticks after it goes high, irq_o and pins_hiz_o are 1 and conv_req_o is 0. Then irq_o and pins_hiz_o fall on the same clock, and conv_req_o rises with chan_sel_o = 0.
- R2: irq_o stays 1 for the whole time the block is held in reset or is counting the release delay.
- R3: If ext_rst_n_i is seen low across at least MIN_PULSE_TICKS ticks, the reset is accepted: measurement stops and irq_o goes high. After the pin rises, irq_o stays high for exactly REL_TICKS ticks, and then a fresh cycle starts at input 0.
- R4: A low pulse on ext_rst_n_i that spans fewer than MIN_PULSE_TICKS ticks is ignored. irq_o stays 0 and the cycle timing is unchanged.
- R5: pins_hiz_o is 1 while ext_rst_n_i is low, two clocks after the pin falls and regardless of pulse width. Outside reset, it returns to 0 two clocks after the pin rises.
- R6: chan_sel_o takes the values 0,1,...,NUM_CH-1 in order within a cycle. It changes only on a clock where conv_done_i is 1 while conv_req_o is 1.
- R7: conv_req_o is 1 throughout a measurement cycle and 0 in every other state. It is never 1 while irq_o is 1.
- R8: On the clock after the last input's done strobe, irq_o is 1 and conv_req_o is 0. irq_o falls on the clock that consumes the next tick.
- R9: Consecutive cycle starts (rising conv_req_o) are LONG_TICKS ticks apart when long_mode_i = 1 and SHORT_TICKS ticks apart when long_mode_i = 0, provided the cycle fits. When it does not fit, the next cycle starts on the clock after irq_o falls.
- R10: long_mode_i is captured on the clock that enters sleep. Changes to it during sleep do not affect that sleep period.
- R11: A conv_done_i strobe while conv_req_o is 0 has no effect on chan_sel_o or on cycle timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-clock strobe from the slow timebase (one per millisecond) |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| long_mode_i | input | 1 | Interval select: 1 long, 0 short |
| conv_done_i | input | 1 | Converter done strobe for the selected input |
| conv_req_o | output | 1 | Conversion request for the selected input |
| chan_sel_o | output | $clog2(NUM_CH) | Input multiplexer select |
| pins_hiz_o | output | 1 | Drive sensor, offset and reference pins to high impedance |
| irq_o | output | 1 | Interrupt: high in reset, one tick at cycle end |

## Verification
The bench builds the block with REL_TICKS = 4, MIN_PULSE_TICKS = 2, LONG_TICKS = 14 and SHORT_TICKS = 8, and applies a tick every 10 clocks. With these values, release delays, rejected and accepted reset pulses, and many cycles in both interval modes all fit into a few thousand clocks. Because 8 inputs with short converter delays fit inside an 80-clock short interval, exact period checks are possible. Forcing slow conversions pushes a cycle past the short interval, which reaches the overrun path.

// File: rtl/sense_sched_pkg.sv
package sense_sched_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_REL_WAIT,
        ST_MEASURE,
        ST_CYCLE_IRQ,
        ST_SLEEP
    } sched_state_e;
endpackage

// File: rtl/sched_rst_filter.sv
module sched_rst_filter #(
    parameter int MIN_PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ext_rst_n_i,
    output logic ext_low_o,
    output logic accept_o
);
    localparam int LW = $clog2(MIN_PULSE_TICKS + 1);
    localparam logic [LW-1:0] LOW_MAX = LW'(MIN_PULSE_TICKS);

    logic          sync1_q;
    logic          sync2_q;
    logic [LW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q   <= 1'b1;
            sync2_q   <= 1'b1;
            low_cnt_q <= '0;
        end else begin
            sync1_q <= ext_rst_n_i;
            sync2_q <= sync1_q;
            if (sync2_q) begin
                low_cnt_q <= '0;
            end else if (tick_i && (low_cnt_q != LOW_MAX)) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign ext_low_o = !sync2_q;
    assign accept_o  = !sync2_q && (low_cnt_q == LOW_MAX);

    // R3
    accept_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> $past(tick_i));

    // R4
    no_accept_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync2_q) |-> !accept_o);
endmodule

// File: rtl/sched_rel_timer.sv
module sched_rel_timer #(
    parameter int REL_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    output logic done_o
);
    localparam int RW = $clog2(REL_TICKS + 1);
    localparam logic [RW-1:0] REL_MAX = RW'(REL_TICKS);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != REL_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == REL_MAX);

    // R1
    rel_done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(tick_i) && $past(run_i)));
endmodule

// File: rtl/sched_ival_timer.sv
module sched_ival_timer #(
    parameter int LONG_TICKS  = 101,
    parameter int SHORT_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    input  logic latch_i,
    input  logic long_mode_i,
    output logic expired_o
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int IW   = $clog2(MAXT + 1);
    localparam logic [IW-1:0] CNT_MAX = IW'(MAXT);

    logic [IW-1:0] per_cnt_q;
    logic [IW-1:0] limit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt_q <= '0;
            limit_q   <= IW'(LONG_TICKS);
        end else begin
            if (restart_i) begin
                per_cnt_q <= '0;
            end else if (tick_i && (per_cnt_q != CNT_MAX)) begin
                per_cnt_q <= per_cnt_q + 1'b1;
            end
            if (latch_i) begin
                limit_q <= long_mode_i ? IW'(LONG_TICKS) : IW'(SHORT_TICKS);
            end
        end
    end

    assign expired_o = (per_cnt_q >= limit_q);

    // R9
    expiry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_o) |-> ($past(tick_i) || $past(latch_i)));

    // R10
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(latch_i) |-> $stable(limit_q));
endmodule

// File: rtl/sense_sched.sv
module sense_sched
    import sense_sched_pkg::*;
#(
    parameter int NUM_CH          = 8,
    parameter int REL_TICKS       = 20,
    parameter int MIN_PULSE_TICKS = 1,
    parameter int LONG_TICKS      = 101,
    parameter int SHORT_TICKS     = 5,
    localparam int CH_W           = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            ext_rst_n_i,
    input  logic            long_mode_i,
    input  logic            conv_done_i,
    output logic            conv_req_o,
    output logic [CH_W-1:0] chan_sel_o,
    output logic            pins_hiz_o,
    output logic            irq_o
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    sched_state_e    state_q, state_d;
    logic [CH_W-1:0] chan_q, chan_d;
    logic            ext_low;
    logic            rst_accept;
    logic            rel_done;
    logic            ival_expired;
    logic            cycle_start;
    logic            sleep_enter;

    sched_rst_filter #(.MIN_PULSE_TICKS(MIN_PULSE_TICKS)) i_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .ext_rst_n_i(ext_rst_n_i),
        .ext_low_o  (ext_low),
        .accept_o   (rst_accept)
    );

    sched_rel_timer #(.REL_TICKS(REL_TICKS)) i_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_i),
        .run_i (state_q == ST_REL_WAIT),
        .done_o(rel_done)
    );

    sched_ival_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) i_ival (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .restart_i  (cycle_start),
        .latch_i    (sleep_enter),
        .long_mode_i(long_mode_i),
        .expired_o  (ival_expired)
    );

    // Next-state and channel stepping
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!ext_low) state_d = ST_REL_WAIT;
            end
            ST_REL_WAIT: begin
                if (rel_done) begin
                    state_d = ST_MEASURE;
                    chan_d  = '0;
                end
            end
            ST_MEASURE: begin
                if (conv_done_i) begin
                    if (chan_q == LAST_CH) begin
                        state_d = ST_CYCLE_IRQ;
                    end else begin
                        chan_d = chan_q + 1'b1;
                    end
                end
            end
            ST_CYCLE_IRQ: begin
                if (tick_i) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (ival_expired) begin
                    state_d = ST_MEASURE;
                    chan_d  = '0;
                end
            end
            default: state_d = ST_HOLD;
        endcase
        if (rst_accept) begin
            state_d = ST_HOLD;
            chan_d  = '0;
        end
    end

    assign cycle_start = (state_d == ST_MEASURE) && (state_q != ST_MEASURE);
    assign sleep_enter = (state_d == ST_SLEEP) && (state_q == ST_CYCLE_IRQ);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REL_WAIT;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    // Outputs
    always_comb begin
        irq_o      = 1'b0;
        conv_req_o = 1'b0;
        pins_hiz_o = ext_low;
        unique case (state_q)
            ST_HOLD, ST_REL_WAIT: begin
                irq_o      = 1'b1;
                pins_hiz_o = 1'b1;
            end
            ST_MEASURE:   conv_req_o = 1'b1;
            ST_CYCLE_IRQ: irq_o      = 1'b1;
            ST_SLEEP:     irq_o      = 1'b0;
            default:      irq_o      = 1'b1;
        endcase
        chan_sel_o = chan_q;
    end

    // R6
    chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_done_i && !rst_accept) |=> $stable(chan_sel_o));

    // R6
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && conv_done_i && (chan_sel_o != LAST_CH) && !rst_accept)
        |=> (chan_sel_o == $past(chan_sel_o) + 1'b1));

    // R6
    cycle_first_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_req_o) |-> (chan_sel_o == '0));

    // R7
    req_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> !irq_o);

    // R8
    cycle_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CYCLE_IRQ && !tick_i && !rst_accept) |=> irq_o);

    // R11
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_req_o && !rst_accept && state_q != ST_SLEEP && state_q != ST_REL_WAIT)
        |=> $stable(chan_sel_o));
endmodule

// File: tb/test_sense_sched.sv
module test_sense_sched;
    localparam int NUM_CH    = 8;
    localparam int REL       = 4;
    localparam int MINP      = 2;
    localparam int LONGT     = 14;
    localparam int SHORTT    = 8;
    localparam int TICK_CLKS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       long_mode = 1'b1;
    logic       conv_done = 1'b0;
    logic       conv_req;
    logic [2:0] chan_sel;
    logic       pins_hiz;
    logic       irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  tick_seen = 0;
    longint cyc = 0;
    longint prev_start = -1;
    bit  prev_mode = 1'b1;

    always #4 clk = ~clk;

    sense_sched #(
        .NUM_CH(NUM_CH), .REL_TICKS(REL), .MIN_PULSE_TICKS(MINP),
        .LONG_TICKS(LONGT), .SHORT_TICKS(SHORTT)
    ) i_sense_sched (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_rst_n_i(ext_rst_n),
        .long_mode_i(long_mode), .conv_done_i(conv_done), .conv_req_o(conv_req),
        .chan_sel_o(chan_sel), .pins_hiz_o(pins_hiz), .irq_o(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tick) tick_seen <= tick_seen + 1;
    end

    initial begin
        forever begin
            repeat (TICK_CLKS - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    function automatic longint period_clks(bit mode);
        return longint'(mode ? LONGT : SHORTT) * TICK_CLKS;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick_done();
        @(posedge clk);
        while (!tick) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_release(string req);
        int t0 = tick_seen;
        int guard = 0;
        while (irq && guard < 2000) begin
            chk(pins_hiz && !conv_req, "R2 reset hold outputs", {pins_hiz, conv_req}, 2);
            @(negedge clk);
            guard++;
        end
        chk(tick_seen - t0 == REL, req, tick_seen - t0, REL);
        chk(!pins_hiz, "R1 hiz falls with irq", pins_hiz, 0);
        chk(conv_req && chan_sel == 0, "R1 cycle starts at input 0", chan_sel, 0);
        prev_start = -1;
    endtask

    task automatic run_cycle(bit mode, int dmin, int dmax, bit check_period);
        int guard = 0;
        longint start;
        long_mode = mode;
        while (!conv_req && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        start = cyc;
        if (check_period && prev_start >= 0)
            chk(start - prev_start == period_clks(prev_mode), "R9/R10 cycle period",
                start - prev_start, period_clks(prev_mode));
        prev_start = start;
        prev_mode  = mode;
        for (int i = 0; i < NUM_CH; i++) begin
            int d = dmin + int'($urandom % 32'(dmax - dmin + 1));
            chk(chan_sel == 3'(i), "R6 input order", chan_sel, i);
            chk(conv_req && !irq, "R7 request during cycle", {conv_req, irq}, 2);
            repeat (d) begin
                @(negedge clk);
                chk(chan_sel == 3'(i), "R6 select stable without done", chan_sel, i);
            end
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
        end
        chk(irq && !conv_req, "R8 end of cycle interrupt", {irq, conv_req}, 2);
        begin
            int t = tick_seen;
            guard = 0;
            while (irq && guard < 100) begin
                @(negedge clk);
                guard++;
            end
            chk(tick_seen == t + 1, "R8 interrupt lasts one tick", tick_seen - t, 1);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(irq && pins_hiz && !conv_req, "R1 power-on reset state",
            {irq, pins_hiz, conv_req}, 6);
        wait_tick_done();
        rst_n = 1'b1;
        wait_release("R1 release delay after power-on");

        // Random cycles in both modes, with mode changes during sleep
        for (int k = 0; k < 8; k++) begin
            bit m = 1'($urandom % 2);
            run_cycle(m, 0, 3, 1'b1);
            if (k == 2) begin
                // R4 short external pulse right after a tick
                ext_rst_n = 1'b0;
                repeat (3) @(negedge clk);
                chk(pins_hiz, "R5 hiz during short pulse", pins_hiz, 1);
                chk(!irq, "R4 short pulse ignored", irq, 0);
                repeat (3) @(negedge clk);
                ext_rst_n = 1'b1;
                repeat (3) @(negedge clk);
                chk(!pins_hiz && !irq, "R5 hiz released after short pulse",
                    {pins_hiz, irq}, 0);
            end else if (k == 4) begin
                // R11 stray done during sleep
                repeat (2) @(negedge clk);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                @(negedge clk);
                chk(chan_sel == 3'd7 && !conv_req, "R11 stray done ignored", chan_sel, 7);
            end else begin
                repeat (5) @(negedge clk);
                long_mode = ~m;  // R10 change during sleep
            end
        end

        // R9 overrun: slow conversions in short mode
        run_cycle(1'b0, 0, 2, 1'b1);
        run_cycle(1'b0, 10, 10, 1'b1);
        @(negedge clk);
        chk(conv_req, "R9 overrun starts next cycle at once", conv_req, 1);
        prev_start = -1;
        run_cycle(1'b1, 0, 3, 1'b1);
        run_cycle(1'b1, 0, 3, 1'b1);

        // R3 accepted external reset in the middle of a cycle
        while (!conv_req) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            @(negedge clk);
        end
        ext_rst_n = 1'b0;
        repeat (45) @(negedge clk);
        chk(irq && pins_hiz && !conv_req, "R3 long pulse accepted",
            {irq, pins_hiz, conv_req}, 6);
        wait_tick_done();
        ext_rst_n = 1'b1;
        wait_release("R3 release delay after external reset");
        run_cycle(1'b0, 0, 3, 1'b1);
        run_cycle(1'b1, 0, 3, 1'b1);
        run_cycle(1'b0, 0, 3, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule